// File: doc/BRIEF.md
# Vectored Interrupt Priority Selector

When a vector-select instruction executes, this block picks one interrupt source out of sixteen ranked sources. The winner is the highest-ranked source that is both pending and enabled. The block then works out where that source's two-byte entry sits in the vector table. It reads the entry through a synchronous memory read port and returns the 16-bit jump target with a one-cycle completion pulse.

The table lives in the same 256-byte page as the vector-select instruction. If the instruction occupies the final byte of a page, the table lives in the following page instead, and page arithmetic wraps modulo 2^16. Reserved ranks are removed by a fixed mask. If no live source is both pending and enabled, the lowest-rank default entry is used and a flag is raised so that error handling can see it.

The block never sets or clears interrupt flags. It does not model a stack or the return from an interrupt.

Top module: `irq_vec_select`

## Requirements
- R1: A vector `req = pending & enable` is formed with a fixed live mask applied. The `rank` output is the lowest set index of `req`, so bit 0 is the highest priority. `rank` value n encodes priority level n+1.
- R2: Bits 1, 7 to 13 and 15 of `pending` are reserved and never win arbitration. The live bits are 0, 2, 3, 4, 5, 6 and 14.
- R3: The low byte of `entry_addr` equals 0xFE minus twice `rank`. Rank 0 therefore maps to offset 0xFE and rank 15 to offset 0xE0.
- R4: Normally, the high byte of `entry_addr` equals the high byte of `instr_addr`. When `instr_addr[7:0]` is 0xFF it is that value plus one, modulo 256, so address 0xFFFF selects page 0x00.
- R5: When `req` is zero at start, `rank` is 15, the entry offset is 0xE0 and `default_used` is 1. Otherwise `default_used` is 0.
- R6: A start accepted at clock edge k produces the following sequence. `mem_rd` is high with `mem_addr` equal to `entry_addr` between edges k and k+1, and high with `mem_addr` equal to `entry_addr`+1 between edges k+1 and k+2. `done` is high for exactly one cycle, from edge k+3.
- R7: `target` is valid while `done` is high. Its upper byte is the byte read at the even entry address and its lower byte is the byte read at the odd address.
- R8: Inputs are captured on the cycle where start is accepted. Changes to `pending`, `enable` or `instr_addr` during a fetch, and any `start` seen while `busy` is high, leave `rank`, `entry_addr` and `target` unchanged.
- R9: While reset is asserted, `done`, `mem_rd`, `busy`, `default_used`, `rank`, `entry_addr` and `target` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Vector-select strobe, accepted when idle |
| pending | input | 16 | Pending flags, bit 0 highest rank |
| enable | input | 16 | Enable bits, same order as pending |
| instr_addr | input | 16 | Address of the vector-select instruction |
| mem_rdata | input | 8 | Read data, one cycle after the address |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | 16 | Read address |
| busy | output | 1 | Fetch in progress |
| rank | output | 4 | Chosen rank index |
| entry_addr | output | 16 | Address of the even byte of the table entry |
| default_used | output | 1 | No live source was pending and enabled |
| target | output | 16 | Jump target |
| done | output | 1 | One-cycle completion pulse |

## Verification
The selection results (`rank`, `entry_addr`, `default_used`) are registered on the accepting edge, so the bench reads them at the falling edge that follows it. The two read addresses are due in the two cycles after that and are checked in those cycles. `done` and `target` are due three edges after acceptance, and the bench also confirms that `done` is low both one cycle earlier and one cycle later. Flags are cleared or rewritten right after acceptance, and a second start is issued mid-fetch, so that each result shows it depends only on the captured inputs.

// File: rtl/irq_vec_select.sv
module irq_vec_select #(
  parameter int          NSRC      = 16,
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter logic [15:0] LIVE_MASK = 16'h407D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NSRC-1:0] pending,
  input  logic [NSRC-1:0] enable,
  input  logic [AW-1:0] instr_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic [3:0]    rank,
  output logic [AW-1:0] entry_addr,
  output logic          default_used,
  output logic [2*DW-1:0] target,
  output logic          done
);
  localparam logic [1:0] IDLE = 2'd0, S_HI = 2'd1, S_LO = 2'd2, S_CAP = 2'd3;

  logic [1:0]      st;
  logic [NSRC-1:0] req;
  logic [3:0]      win;
  logic            hit;
  logic [3:0]      sel;
  logic [7:0]      page, offs;
  logic [DW-1:0]   hi_q;
  logic            go;

  assign req  = pending & enable & LIVE_MASK;
  assign go   = start && st == IDLE;
  assign busy = st != IDLE;

  always_comb begin
    win = 4'd0;
    hit = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) begin
        win = 4'(i);
        hit = 1'b1;
      end
  end

  assign sel  = hit ? win : 4'd15;
  assign offs = 8'hFE - {3'b000, sel, 1'b0};
  assign page = instr_addr[AW-1:AW-8] + {7'd0, &instr_addr[7:0]};

  assign mem_rd   = st == S_HI || st == S_LO;
  assign mem_addr = {entry_addr[AW-1:1], st == S_LO};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= IDLE;
      rank         <= '0;
      entry_addr   <= '0;
      default_used <= 1'b0;
      hi_q         <= '0;
      target       <= '0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          rank         <= sel;
          entry_addr   <= {page, offs};
          default_used <= !hit;
          st           <= S_HI;
        end
        S_HI: st <= S_LO;
        S_LO: begin
          hi_q <= mem_rdata;
          st   <= S_CAP;
        end
        default: begin
          target <= {hi_q, mem_rdata};
          done   <= 1'b1;
          st     <= IDLE;
        end
      endcase
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> mem_rd && !mem_addr[0]);
  a_r6_second_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_addr[0]) |=> mem_rd && mem_addr[0]);
  a_r5_default_entry: assert property (@(posedge clk) disable iff (!rst_n)
    default_used |-> rank == 4'd15 && entry_addr[7:0] == 8'hE0);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rank) && $stable(entry_addr));
  a_r3_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> entry_addr[7:5] == 3'b111 && !entry_addr[0]);
endmodule

// File: tb/sim_irq_vec_select.sv
module sim_irq_vec_select;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [15:0] pending = 0, enable = 0, instr_addr = 0;
  logic [7:0]  mem_rdata;
  logic        mem_rd, busy, default_used, done;
  logic [15:0] mem_addr, entry_addr, target;
  logic [3:0]  rank;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_vec_select u0 (.clk, .rst_n, .start, .pending, .enable, .instr_addr,
    .mem_rdata, .mem_rd, .mem_addr, .busy, .rank, .entry_addr,
    .default_used, .target, .done);

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem_f(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pending, enable, instr_addr, rank, entry, default
  localparam logic [68:0] VEC [8] = '{
    {16'h0001, 16'hFFFF, 16'h1234, 4'd0,  16'h12FE, 1'b0},
    {16'h007C, 16'hFFFF, 16'h2000, 4'd2,  16'h20FA, 1'b0},
    {16'h0002, 16'hFFFF, 16'h30FF, 4'd15, 16'h31E0, 1'b1},
    {16'h4000, 16'h4000, 16'hFFFF, 4'd14, 16'h00E2, 1'b0},
    {16'h0070, 16'h0060, 16'h4510, 4'd5,  16'h45F4, 1'b0},
    {16'hFFFF, 16'h0000, 16'h0000, 4'd15, 16'h00E0, 1'b1},
    {16'hBF80, 16'hFFFF, 16'h7777, 4'd15, 16'h77E0, 1'b1},
    {16'h0018, 16'h0010, 16'hABFE, 4'd4,  16'hABF6, 1'b0}
  };

  task automatic run(input logic [15:0] p, input logic [15:0] e, input logic [15:0] a,
                     input logic [3:0] xr, input logic [15:0] xe, input logic xd,
                     input bit poke);
    @(negedge clk);
    pending = p; enable = e; instr_addr = a; start = 1;
    @(negedge clk);
    start = poke;
    pending = 16'h0001; enable = 16'hFFFF; instr_addr = 16'h9999;
    chk("R1 rank", rank, xr);
    chk("R3/R4 entry", entry_addr, xe);
    chk("R5 default", default_used, xd);
    chk("R6 first read", {mem_rd, mem_addr}, {1'b1, xe});
    @(negedge clk);
    chk("R6 second read", {mem_rd, mem_addr}, {1'b1, xe | 16'h1});
    @(negedge clk);
    start = 0;
    chk("R6 done early", done, 0);
    @(negedge clk);
    chk("R6 done", done, 1);
    chk("R7 target", target, {mem_f(xe), mem_f(xe | 16'h1)});
    chk("R8 rank held", rank, xr);
    @(negedge clk);
    chk("R6 done single", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset", {done, mem_rd, busy, default_used, rank, entry_addr, target},
        '0);
    rst_n = 1;
    foreach (VEC[i])
      run(VEC[i][68:53], VEC[i][52:37], VEC[i][36:21], VEC[i][20:17],
          VEC[i][16:1], VEC[i][0], 0);
    // R2: reserved bit 1 alone with live bit 14 -> 14 wins
    run(16'h4002, 16'hFFFF, 16'h0500, 4'd14, 16'h05E2, 0, 0);
    // R8: start held during fetch is ignored
    run(16'h0008, 16'hFFFF, 16'h0100, 4'd3, 16'h01F8, 0, 1);
    // R4: last byte of a mid page
    run(16'h0004, 16'h0004, 16'h12FF, 4'd2, 16'h13FA, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule